// File: doc/BRIEF.md
# Banked Interrupt Request Aggregator

The block gathers a set of peripheral interrupt request pins into byte-wide banks and presents them to a host processor as one combined interrupt line. Each bank has a status byte and an enable byte on a small byte-wide register bus. Most request pins are edge-triggered. A rising edge on an enabled pin is latched into its status bit, and the latch is cleared when the host reads that bank's status byte. No separate acknowledge write exists. One designated pin is level-triggered. Its status bit follows the synchronized pin level, and reading the status byte does not change it.

The host finds pending work by ANDing each status byte with its enable byte. The combined output is a registered OR of all enabled pending bits. The host detects rising edges on that line. A fresh host interrupt therefore needs the line to drop after the host has drained the banks. A rising edge that arrives while its enable bit is 0 is dropped, and it stays dropped when the enable bit is later set.

Bus accesses take one cycle. A request seen at a clock edge is decoded into one of seven access kinds: idle, status read, enable read, enable write, status write, unmapped read and unmapped write. The decoded kind selects the action at that same edge. Read data appears on the cycle after the request.

Top module: `irq_bank_aggregator`

## Requirements
- R1: With NUM_BANKS banks, bank b has its status byte at offset 2b and its enable byte at offset 2b+1. Source s is bit s mod BANK_W of bank s / BANK_W. Read data is valid on the cycle after the request and holds until the next read. Reads of offsets at or above 2·NUM_BANKS return 0.
- R2: Writing an enable offset stores the byte, and reading it back returns the same byte. An enable bit of 1 enables its source, and 0 disables it.
- R3: After reset, every enable byte is 0, every status bit is 0 while the pins are low, and irq_out is 0.
- R4: A rising edge on an enabled edge-triggered pin passes through a two-flop synchronizer and sets its status bit at the third clock edge after the pin rises.
- R5: A status read returns the byte as it stood before the read. The read clears that bank's edge-triggered status bits at the same clock edge and leaves the other banks unchanged.
- R6: irq_out is 1 on the cycle after any status bit is set together with its enable bit. Otherwise irq_out is 0.
- R7: A rising edge that occurs while its enable bit is 0 is never captured, even after the enable bit is set while the pin stays high.
- R8: Writes to status offsets change neither the enable bytes nor the status bits.
- R9: The status bit of source LEVEL_IDX (default 20, which is bank 2, bit 4) follows the synchronized pin level and is not cleared by a status read.
- R10: If an edge capture and a status read of its bank fall on the same clock edge, the status bit stays set after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pins | input | NUM_BANKS*BANK_W | Peripheral request pins |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | $clog2(2*NUM_BANKS) | Register byte offset |
| bus_wdata | input | BANK_W | Write data |
| bus_rdata | output | BANK_W | Read data, valid on the cycle after a read |
| irq_out | output | 1 | Combined interrupt to the host |

## Verification
The bench builds the block with its defaults: three banks of eight bits and the level-triggered source at index 20. With these values, every bank's status and enable offsets can be reached, along with the two unmapped offsets 6 and 7. The level source sits in the top bank beside edge sources, so the bench can check that a read of the top bank clears its edge bits but keeps the level bit. The bench times one re-arming pulse so that its capture lands on the same edge as a status read, which exercises the case where the new edge must win.

// File: rtl/irqagg_pkg.sv
`timescale 1ns/1ps
package irqagg_pkg;
    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_STAT_RD,
        ACC_MASK_RD,
        ACC_MASK_WR,
        ACC_STAT_WR,
        ACC_VOID_RD,
        ACC_VOID_WR
    } acc_e;
endpackage

// File: rtl/irqagg_sync2.sv
`timescale 1ns/1ps
module irqagg_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= d_in;
            s2_q <= s1_q;
        end
    end

    assign q_out = s2_q;
endmodule

// File: rtl/irqagg_src.sv
`timescale 1ns/1ps
module irqagg_src #(
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic en_bit,
    input  logic clr,
    output logic stat,
    output logic cap_set
);
    logic lvl;

    irqagg_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin),
        .q_out (lvl)
    );

    generate
        if (IS_LEVEL) begin : g_level
            // The bit tracks the pin; a read has no effect on it.
            assign stat    = lvl;
            assign cap_set = 1'b0;
        end else begin : g_edge
            logic prev_q, cap_q, rise;

            assign rise    = lvl & ~prev_q;
            assign cap_set = rise & en_bit;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev_q <= 1'b0;
                    cap_q  <= 1'b0;
                end else begin
                    prev_q <= lvl;
                    // A capture on the same edge as a clear takes precedence.
                    cap_q  <= (cap_q & ~clr) | cap_set;
                end
            end

            assign stat = cap_q;
        end
    endgenerate
endmodule

// File: rtl/irqagg_regif.sv
`timescale 1ns/1ps
module irqagg_regif
    import irqagg_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 8,
    parameter int ADDR_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [BANK_W-1:0]             bus_wdata,
    input  logic [NUM_BANKS*BANK_W-1:0]   status_all,
    output logic [NUM_BANKS*BANK_W-1:0]   mask_all,
    output logic [NUM_BANKS-1:0]          clr_bank,
    output logic [BANK_W-1:0]             bus_rdata
);
    localparam int NREG = 2 * NUM_BANKS;

    acc_e              acc_d;
    logic [ADDR_W-1:0] bank_idx;
    logic              in_range;
    logic              mask_we;
    logic [BANK_W-1:0] stat_sel, mask_sel, rdata_d, rdata_q;
    logic [BANK_W-1:0] mask_q [NUM_BANKS];

    assign bank_idx = bus_addr >> 1;
    assign in_range = int'(bus_addr) < NREG;

    always_comb begin
        stat_sel = '0;
        mask_sel = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(bank_idx) == b) begin
                stat_sel = status_all[b*BANK_W +: BANK_W];
                mask_sel = mask_q[b];
            end
        end
    end

    // Access decode: classify this cycle's request.
    always_comb begin
        if (!bus_sel)
            acc_d = ACC_IDLE;
        else if (!in_range)
            acc_d = bus_wr ? ACC_VOID_WR : ACC_VOID_RD;
        else if (bus_addr[0])
            acc_d = bus_wr ? ACC_MASK_WR : ACC_MASK_RD;
        else
            acc_d = bus_wr ? ACC_STAT_WR : ACC_STAT_RD;
    end

    // Actions of each access kind.
    always_comb begin
        clr_bank = '0;
        mask_we  = 1'b0;
        rdata_d  = rdata_q;
        unique case (acc_d)
            ACC_STAT_RD: begin
                rdata_d = stat_sel;
                for (int b = 0; b < NUM_BANKS; b++)
                    if (int'(bank_idx) == b) clr_bank[b] = 1'b1;
            end
            ACC_MASK_RD: rdata_d = mask_sel;
            ACC_MASK_WR: mask_we = 1'b1;
            ACC_VOID_RD: rdata_d = '0;
            ACC_IDLE, ACC_STAT_WR, ACC_VOID_WR: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            for (int b = 0; b < NUM_BANKS; b++) mask_q[b] <= '0;
        end else begin
            rdata_q <= rdata_d;
            for (int b = 0; b < NUM_BANKS; b++)
                if (mask_we && int'(bank_idx) == b) mask_q[b] <= bus_wdata;
        end
    end

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mask
            assign mask_all[b*BANK_W +: BANK_W] = mask_q[b];
        end
    endgenerate

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/irq_bank_aggregator.sv
`timescale 1ns/1ps
module irq_bank_aggregator #(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 8,
    parameter int LEVEL_IDX = 20,
    parameter int ADDR_W    = $clog2(2 * NUM_BANKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0] irq_pins,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [BANK_W-1:0]           bus_wdata,
    output logic [BANK_W-1:0]           bus_rdata,
    output logic                        irq_out
);
    localparam int NSRC = NUM_BANKS * BANK_W;

    logic [NSRC-1:0]      status_all;
    logic [NSRC-1:0]      mask_all;
    logic [NSRC-1:0]      cap_set_all;
    logic [NUM_BANKS-1:0] clr_bank;
    logic                 irq_q;

    irqagg_regif #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .ADDR_W    (ADDR_W)
    ) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .status_all (status_all),
        .mask_all   (mask_all),
        .clr_bank   (clr_bank),
        .bus_rdata  (bus_rdata)
    );

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            irqagg_src #(
                .IS_LEVEL (i == LEVEL_IDX)
            ) u_src (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin     (irq_pins[i]),
                .en_bit  (mask_all[i]),
                .clr     (clr_bank[i / BANK_W]),
                .stat    (status_all[i]),
                .cap_set (cap_set_all[i])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status_all & mask_all);
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/irqagg_checker.sv
`timescale 1ns/1ps
module irqagg_checker #(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 8,
    parameter int LEVEL_IDX = 20,
    parameter int ADDR_W    = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_BANKS*BANK_W-1:0] status_all,
    input logic [NUM_BANKS*BANK_W-1:0] mask_all,
    input logic [NUM_BANKS*BANK_W-1:0] cap_set_all,
    input logic [NUM_BANKS-1:0]        clr_bank,
    input logic                        bus_sel,
    input logic                        bus_wr,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [BANK_W-1:0]           bus_wdata,
    input logic                        irq_out
);
    localparam int NSRC = NUM_BANKS * BANK_W;
    localparam logic [NSRC-1:0] EDGE_BITS = ~(NSRC'(1) << LEVEL_IDX);

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_all & mask_all)) |=> irq_out); // R6
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status_all & mask_all)) |=> !irq_out); // R6
    AST_MASK_RESET: assert property (@(posedge clk)
        !rst_n |=> (mask_all == '0)); // R3
    AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_addr[0]) |=> $stable(mask_all)); // R8
    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_bank)); // R5

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_sel && bus_wr && bus_addr == ADDR_W'(2*b+1))
                |=> (mask_all[b*BANK_W +: BANK_W] == $past(bus_wdata))); // R2
            AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
                clr_bank[b] |=> ((status_all[b*BANK_W +: BANK_W]
                    & EDGE_BITS[b*BANK_W +: BANK_W]
                    & ~$past(cap_set_all[b*BANK_W +: BANK_W])) == '0)); // R5
        end
        for (genvar i = 0; i < NSRC; i++) begin : g_bit
            if (i != LEVEL_IDX) begin : g_edge
                AST_MASKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
                    (!status_all[i] && !mask_all[i]) |=> !status_all[i]); // R7
                AST_NEW_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                    cap_set_all[i] |=> status_all[i]); // R10
            end
        end
    endgenerate
endmodule

bind irq_bank_aggregator irqagg_checker #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .LEVEL_IDX (LEVEL_IDX),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_all  (status_all),
    .mask_all    (mask_all),
    .cap_set_all (cap_set_all),
    .clr_bank    (clr_bank),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .irq_out     (irq_out)
);

// File: tb/irq_bank_aggregator_tb.sv
`timescale 1ns/1ps
module irq_bank_aggregator_tb;
    localparam int NB = 3;
    localparam int BW = 8;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB*BW-1:0] pins = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [BW-1:0] bus_wdata = '0;
    logic [BW-1:0] bus_rdata;
    logic          irq_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    irq_bank_aggregator u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_pins  (pins),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_read(input int addr, output logic [BW-1:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(addr);
        @(negedge clk);
        bus_sel = 1'b0;
        data = bus_rdata;
    endtask

    task automatic bus_write(input int addr, input logic [BW-1:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int src);
        @(negedge clk); pins[src] = 1'b1;
        idle(2);        pins[src] = 1'b0;
        idle(4);
    endtask

    task automatic t_reset();
        logic [BW-1:0] d;
        check("R3 irq_out after reset", int'(irq_out), 0);
        for (int b = 0; b < NB; b++) begin
            bus_read(2*b+1, d); check("R3 enable byte after reset", int'(d), 0);
            bus_read(2*b, d);   check("R3 status byte after reset", int'(d), 0);
        end
    endtask

    task automatic t_mask_rw();
        logic [BW-1:0] d;
        bus_write(1, 8'hA5); bus_write(3, 8'h3C); bus_write(5, 8'h81);
        bus_read(1, d); check("R2 enable readback bank0", int'(d), 'hA5);
        bus_read(3, d); check("R2 enable readback bank1", int'(d), 'h3C);
        bus_read(5, d); check("R2 enable readback bank2", int'(d), 'h81);
        bus_read(6, d); check("R1 unmapped offset 6", int'(d), 0);
        bus_read(7, d); check("R1 unmapped offset 7", int'(d), 0);
        for (int b = 0; b < NB; b++) bus_write(2*b+1, 8'hFF);
    endtask

    task automatic t_edge_capture();
        logic [BW-1:0] d;
        pulse(3);
        check("R6 irq_out high on enabled capture", int'(irq_out), 1);
        bus_read(0, d); check("R4 captured edge source 3", int'(d), 'h08);
        idle(2);
        check("R6 irq_out low after drain", int'(irq_out), 0);
        bus_read(0, d); check("R5 status cleared by read", int'(d), 0);
        @(negedge clk); pins[9] = 1'b1; pins[17] = 1'b1;
        idle(2); pins[9] = 1'b0; pins[17] = 1'b0;
        idle(4);
        bus_read(2, d); check("R1 source 9 in bank1 bit1", int'(d), 'h02);
        bus_read(2, d); check("R5 bank1 cleared", int'(d), 0);
        bus_read(4, d); check("R5 bank2 untouched by bank1 read", int'(d), 'h02);
        bus_read(4, d); check("R5 bank2 cleared", int'(d), 0);
    endtask

    task automatic t_masked_drop();
        logic [BW-1:0] d;
        bus_write(1, 8'hFE);
        @(negedge clk); pins[0] = 1'b1;
        idle(5);
        bus_read(0, d); check("R7 masked edge not captured", int'(d), 0);
        bus_write(1, 8'hFF);
        idle(5);
        bus_read(0, d); check("R7 masked edge not recovered", int'(d), 0);
        check("R7 irq_out stays low", int'(irq_out), 0);
        pins[0] = 1'b0;
        idle(3);
    endtask

    task automatic t_level();
        logic [BW-1:0] d;
        @(negedge clk); pins[20] = 1'b1;
        idle(4);
        bus_read(4, d); check("R9 level bit follows pin", int'(d), 'h10);
        bus_read(4, d); check("R9 level bit kept after read", int'(d), 'h10);
        check("R6 irq_out from level source", int'(irq_out), 1);
        pins[20] = 1'b0;
        idle(4);
        bus_read(4, d); check("R9 level bit drops with pin", int'(d), 0);
        check("R6 irq_out low with level low", int'(irq_out), 0);
    endtask

    task automatic t_stat_write();
        logic [BW-1:0] d;
        pulse(5);
        bus_write(0, 8'h00); bus_write(2, 8'hFF);
        bus_read(1, d); check("R8 enable unchanged by status write", int'(d), 'hFF);
        bus_read(0, d); check("R8 status unchanged by status write", int'(d), 'h20);
        bus_read(2, d); check("R8 bank1 status not set by write", int'(d), 0);
    endtask

    task automatic t_coincide();
        logic [BW-1:0] d;
        pulse(12);
        @(negedge clk); pins[12] = 1'b1;
        @(negedge clk);
        bus_read(2, d); check("R5 snapshot before clear", int'(d), 'h10);
        pins[12] = 1'b0;
        bus_read(2, d); check("R10 new edge survives read", int'(d), 'h10);
        bus_read(2, d); check("R10 cleared by following read", int'(d), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_mask_rw();
        t_edge_capture();
        t_masked_drop();
        t_level();
        t_stat_write();
        t_coincide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule